// File: doc/BRIEF.md
# SMBus Control-Register Slave

This block is a two-wire serial slave for a clock-generator style control plane. It watches oversampled SCL and SDA lines on the system clock. It pulls SDA low through an open-drain enable, and it holds a bank of eight 8-bit control registers. The contents of the bank are driven out in parallel as one flat vector. Downstream logic takes output enables, spread-spectrum selects and test-mode controls from that vector.

The host reaches the bank in one of two ways, chosen by the top bit of the command byte:

- **Single indexed-byte access.** The low five bits of the command give the offset. One byte is written, or one byte is read back after a repeated START.
- **Counted sequential block access.** It always begins at register 0. A write sends a byte-count byte and then data. A read returns a byte-count byte and then the registers in rising order.

A two-bit chip-select field in the command must match before the slave takes any part in the transfer. A START or STOP that arrives in the middle of a byte abandons the transfer. A mismatch leaves SDA untouched until the next START.

Top module: `smb_ctl_slave`

## Requirements
- R1: Reset loads the bank with register 0..7 = 7Ch, 00h, EBh, BFh, 01h, 00h, 13h, 38h, and SDA is not driven.
- R2: The slave acknowledges the address byte D2h (write) and D3h (read), which is the 7-bit address 1101001 followed by the direction bit, 0 for write and 1 for read. For any other address it drives SDA on no bit until the next START, and no register changes.
- R3: A command with bit 7 = 1 selects byte mode, with the register offset in bits 4:0. In a byte write the slave ACKs the address, command and data bytes, and stores the data at that offset.
- R4: Command bits 6:5 must be 00. Otherwise the command byte and all bytes after it get no ACK, and the registers keep their values.
- R5: In a byte read, after the repeated START and D3h, the slave sends the register at the stored offset, MSB first. Once the host NACKs, SDA is released.
- R6: A command with bit 7 = 0 selects block mode. In a block write the slave ACKs the count byte and every data byte, and writes the data to registers 0, 1, 2 and onward. A STOP after any complete byte ends the transfer, and later registers keep their values.
- R7: In a block read the slave first sends the count byte 08h, then registers 0 upward, continuing while the host ACKs.
- R8: Reading past the last register, or at a byte offset of 8 or more, returns 00h. Data written past the last register, or to an offset of 8 or more, is acknowledged and discarded.
- R9: Register 7 holds a revision code in bits 7:4 and a vendor ID in bits 3:0. It is read-only: byte or block writes to it leave it unchanged.
- R10: A STOP or START in the middle of a byte abandons the transfer. The partial byte is not stored, SDA is released, and the next transfer works normally.
- R11: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_flat | output | REG_COUNT*8 | Register bank, byte i at bits 8i+7:8i |

## Verification
The bench builds the block with eight registers and a two-stage input synchronizer. With eight registers, a ten-byte block write and a block read that runs two bytes past the end are enough to reach the saturating pointer and the zero-fill. The read-only top register also falls inside every full block write. The bus is modelled as a wired-AND of host and slave, with SCL low periods much longer than the synchronizer delay. This lets the bench check that the slave's SDA edges always fall inside SCL low.

// File: rtl/smb_pkg.sv
package smb_pkg;

  // Width of the offset field carried in a byte-mode command.
  localparam int CMD_OFS_W = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_WCOUNT,
    S_WDATA,
    S_RD,
    S_SKIP
  } smb_state_t;

  // Power-up contents of the control bank; indices past 7 start at zero.
  function automatic logic [7:0] smb_default(input int idx);
    case (idx)
      0:       return 8'h7C;
      1:       return 8'h00;
      2:       return 8'hEB;
      3:       return 8'hBF;
      4:       return 8'h01;
      5:       return 8'h00;
      6:       return 8'h13;
      7:       return 8'h38;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // One extra stage past the synchronizer keeps the previous sample.
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe;
  logic [PIPE_W-1:0] sda_pipe;
  logic              scl_p;
  logic              sda_p;

  // Lines idle high, so reset fills the pipes with ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_in};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_in};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign scl_p = scl_pipe[SYNC_STAGES];
  assign sda_p = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // An SDA edge while SCL stays high is a bus condition, not data.
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int RO_INDEX  = REG_COUNT - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CMD_OFS_W-1:0]   wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [CMD_OFS_W-1:0]   rd_addr,
  output logic [7:0]             rd_data,
  output logic [REG_COUNT*8-1:0] cfg_flat
);

  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam logic [CMD_OFS_W-1:0] ADDR_END = CMD_OFS_W'(REG_COUNT);
  localparam logic [CMD_OFS_W-1:0] RO_ADDR  = CMD_OFS_W'(RO_INDEX);

  logic [7:0] regs [REG_COUNT];
  logic       wr_hit;

  // Writes land only inside the bank and never on the read-only identity byte.
  assign wr_hit = wr_en && (wr_addr < ADDR_END) && (wr_addr != RO_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= smb_default(i);
    end else if (wr_hit) begin
      regs[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr < ADDR_END) rd_data = regs[rd_addr[IDX_W-1:0]];
    else                    rd_data = 8'h00;
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_export
    assign cfg_flat[g*8 +: 8] = regs[g];
  end

endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_pkg::*;
#(
  parameter int         REG_COUNT = 8,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [1:0] CHIP_SEL  = 2'b00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 sda_s,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [7:0]           rd_data,
  output logic [CMD_OFS_W-1:0] ptr,
  output logic                 wr_en,
  output logic [CMD_OFS_W-1:0] wr_addr,
  output logic [7:0]           wr_data,
  output logic                 sda_oe
);

  localparam logic [CMD_OFS_W-1:0] PTR_END    = CMD_OFS_W'(REG_COUNT);
  localparam logic [7:0]           COUNT_BYTE = 8'(REG_COUNT);

  smb_state_t     st;
  smb_state_t     st_after;
  logic [3:0]     bit_cnt;
  logic           in_ack;
  logic           cnt_pend;
  logic           blk_mode;
  logic [7:0]     rx_sh;
  logic [6:0]     tx_sh;
  logic [7:0]     tx_next;
  logic [CMD_OFS_W-1:0] ptr_inc;
  logic           byte_done;
  logic           addr_hit;
  logic           cs_hit;

  always_comb begin
    // The pointer stops one past the bank so long transfers never wrap back.
    ptr_inc   = (ptr < PTR_END) ? ptr + 1'b1 : ptr;
    tx_next   = cnt_pend ? COUNT_BYTE : rd_data;
    byte_done = scl_fall && !in_ack && (bit_cnt == 4'd8);
    addr_hit  = (rx_sh[7:1] == DEV_ADDR);
    cs_hit    = (rx_sh[6:5] == CHIP_SEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      st_after <= S_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      cnt_pend <= 1'b0;
      blk_mode <= 1'b1;
      ptr      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det || stop_det) begin
        // Any bus condition drops the byte in flight and frees the line.
        st      <= start_det ? S_ADDR : S_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WCOUNT, S_WDATA: begin
            if (scl_rise && !in_ack && (bit_cnt != 4'd8)) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (byte_done) begin
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  in_ack   <= 1'b1;
                  sda_oe   <= 1'b1;
                  st_after <= rx_sh[0] ? S_RD : S_CMD;
                  cnt_pend <= rx_sh[0] & blk_mode;
                end else begin
                  st <= S_SKIP;
                end
              end else if (st == S_CMD) begin
                if (cs_hit) begin
                  in_ack   <= 1'b1;
                  sda_oe   <= 1'b1;
                  blk_mode <= ~rx_sh[7];
                  ptr      <= rx_sh[7] ? rx_sh[CMD_OFS_W-1:0] : '0;
                  st_after <= rx_sh[7] ? S_WDATA : S_WCOUNT;
                end else begin
                  st <= S_SKIP;
                end
              end else if (st == S_WCOUNT) begin
                in_ack   <= 1'b1;
                sda_oe   <= 1'b1;
                st_after <= S_WDATA;
              end else begin
                in_ack   <= 1'b1;
                sda_oe   <= 1'b1;
                wr_en    <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= rx_sh;
                ptr      <= ptr_inc;
                st_after <= S_WDATA;
              end
            end else if (scl_fall && in_ack) begin
              in_ack  <= 1'b0;
              bit_cnt <= '0;
              st      <= st_after;
              if (st_after == S_RD) begin
                tx_sh    <= tx_next[6:0];
                sda_oe   <= ~tx_next[7];
                cnt_pend <= 1'b0;
                if (!cnt_pend) ptr <= ptr_inc;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          S_RD: begin
            if (scl_rise) begin
              if (in_ack) begin
                // Host NACK ends the read; stay off the line until the next condition.
                if (sda_s) begin
                  st     <= S_SKIP;
                  in_ack <= 1'b0;
                end
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
            if (scl_fall) begin
              if (in_ack) begin
                tx_sh    <= tx_next[6:0];
                sda_oe   <= ~tx_next[7];
                cnt_pend <= 1'b0;
                if (!cnt_pend) ptr <= ptr_inc;
                in_ack   <= 1'b0;
                bit_cnt  <= '0;
              end else if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                in_ack <= 1'b1;
              end else begin
                sda_oe <= ~tx_sh[6];
                tx_sh  <= {tx_sh[5:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_ctl_slave.sv
module smb_ctl_slave
  import smb_pkg::*;
#(
  parameter int         REG_COUNT   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [1:0] CHIP_SEL    = 2'b00,
  parameter int         RO_INDEX    = REG_COUNT - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_oe,
  output logic [REG_COUNT*8-1:0] cfg_flat
);

  logic                 scl_s;
  logic                 sda_s;
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 start_det;
  logic                 stop_det;
  logic [CMD_OFS_W-1:0] ptr;
  logic                 wr_en;
  logic [CMD_OFS_W-1:0] wr_addr;
  logic [7:0]           wr_data;
  logic [7:0]           rd_data;

  smb_line_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smb_proto #(
    .REG_COUNT(REG_COUNT),
    .DEV_ADDR (DEV_ADDR),
    .CHIP_SEL (CHIP_SEL)
  ) u_proto (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  smb_reg_bank #(
    .REG_COUNT(REG_COUNT),
    .RO_INDEX (RO_INDEX)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data),
    .cfg_flat(cfg_flat)
  );

endmodule

// File: rtl/smb_ctl_slave_chk.sv
module smb_ctl_slave_chk
  import smb_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int RO_INDEX  = REG_COUNT - 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_s,
  input logic                   start_det,
  input logic                   stop_det,
  input logic                   sda_oe,
  input logic [REG_COUNT*8-1:0] cfg_flat
);

  function automatic logic [REG_COUNT*8-1:0] def_image();
    logic [REG_COUNT*8-1:0] v;
    v = '0;
    for (int i = 0; i < REG_COUNT; i++) v[i*8 +: 8] = smb_default(i);
    return v;
  endfunction

  localparam logic [REG_COUNT*8-1:0] DEF_IMG = def_image();

  // R1: first cycle out of reset shows the power-up image
  a_r1_reset_image: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_flat == DEF_IMG))
    else $error("a_r1_reset_image");

  // R9: the identity byte never moves outside reset
  a_r9_ro_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_flat[RO_INDEX*8 +: 8]))
    else $error("a_r9_ro_hold");

  // R10: a STOP frees the line on the next cycle
  a_r10_stop_frees: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe)
    else $error("a_r10_stop_frees");

  // R10: a START frees the line on the next cycle
  a_r10_start_frees: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe)
    else $error("a_r10_start_frees");

  // R11: the drive moves only while the synchronized clock is low
  a_r11_edge_in_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s)
    else $error("a_r11_edge_in_low");

endmodule

bind smb_ctl_slave smb_ctl_slave_chk #(
  .REG_COUNT(REG_COUNT),
  .RO_INDEX (RO_INDEX)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .cfg_flat (cfg_flat)
);

// File: tb/tb_smb_ctl_slave.sv
module tb_smb_ctl_slave;

  localparam int NREG = 8;
  localparam int H    = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            host_scl = 1'b1;
  logic            host_low = 1'b0;
  logic            sda_oe;
  logic [NREG*8-1:0] cfg;
  wire             sda_bus = ~(host_low | sda_oe);

  int n_chk = 0;
  int n_bad = 0;
  int hi_moves = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;
  logic [7:0] exp_reg [NREG];

  always #5 clk = ~clk;

  smb_ctl_slave #(.REG_COUNT(NREG), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .scl_in(host_scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .cfg_flat(cfg)
  );

  // R11 monitor: the slave's drive must never move while the host holds SCL high
  always @(negedge clk) begin
    if (!rst && (sda_oe !== oe_prev) && host_scl) hi_moves++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, {24'h0, cfg[i*8 +: 8]}, {24'h0, exp_reg[i]});
  endtask

  task automatic bit_out(input logic b);
    host_low = ~b;
    tick(H);
    host_scl = 1'b1;
    tick(H);
    host_scl = 1'b0;
    tick(2);
  endtask

  task automatic bit_in(output logic b);
    host_low = 1'b0;
    tick(H);
    host_scl = 1'b1;
    tick(H / 2);
    b = sda_bus;
    tick(H / 2);
    host_scl = 1'b0;
    tick(2);
  endtask

  task automatic bus_start();
    host_low = 1'b0;
    tick(H);
    host_scl = 1'b1;
    tick(H);
    host_low = 1'b1;
    tick(H);
    host_scl = 1'b0;
    tick(2);
  endtask

  task automatic bus_stop();
    host_low = 1'b1;
    tick(H);
    host_scl = 1'b1;
    tick(H);
    host_low = 1'b0;
    tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~ack);
  endtask

  task automatic byte_write(input string tag, input logic [4:0] ofs, input logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte({3'b100, ofs}, a1);
    wr_byte(d, a2);
    bus_stop();
    chk({tag, " acks"}, {29'h0, a0, a1, a2}, 32'h7);
  endtask

  task automatic byte_read(input string tag, input logic [4:0] ofs, input logic [7:0] expv);
    logic a0, a1, a2;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte({3'b100, ofs}, a1);
    bus_start();
    wr_byte(8'hD3, a2);
    rd_byte(d, 1'b0);
    chk({tag, " released after NACK"}, {31'h0, sda_oe}, 32'h0);
    bus_stop();
    chk({tag, " acks"}, {29'h0, a0, a1, a2}, 32'h7);
    chk({tag, " data"}, {24'h0, d}, {24'h0, expv});
  endtask

  task automatic t_reset();
    chk_regs("R1 reset image");
    chk("R1 SDA idle", {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic t_byte_ops();
    byte_write("R3 byte write ofs3", 5'd3, 8'hA5);
    exp_reg[3] = 8'hA5;
    chk_regs("R3 bank after byte write");
    byte_read("R5 byte read ofs3", 5'd3, 8'hA5);
    byte_read("R5 byte read ofs0", 5'd0, 8'h7C);
    byte_read("R9 byte read ofs7", 5'd7, 8'h38);
  endtask

  task automatic t_block_short();
    logic a0, a1, a2;
    logic [2:0] ad;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h00, a1);
    wr_byte(8'd3, a2);
    wr_byte(8'h11, ad[0]);
    wr_byte(8'h22, ad[1]);
    wr_byte(8'h33, ad[2]);
    bus_stop();
    chk("R6 block write header acks", {29'h0, a0, a1, a2}, 32'h7);
    chk("R6 block write data acks", {29'h0, ad}, 32'h7);
    exp_reg[0] = 8'h11; exp_reg[1] = 8'h22; exp_reg[2] = 8'h33;
    chk_regs("R6 bank after short block write");
  endtask

  task automatic t_block_read();
    logic a0, a1, a2;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h00, a1);
    bus_start();
    wr_byte(8'hD3, a2);
    chk("R7 block read acks", {29'h0, a0, a1, a2}, 32'h7);
    rd_byte(d, 1'b1);
    chk("R7 count byte", {24'h0, d}, 32'h08);
    for (int i = 0; i < NREG; i++) begin
      rd_byte(d, 1'b1);
      chk("R7 block read data", {24'h0, d}, {24'h0, exp_reg[i]});
    end
    rd_byte(d, 1'b1);
    chk("R8 read past end", {24'h0, d}, 32'h0);
    rd_byte(d, 1'b0);
    chk("R8 read past end last", {24'h0, d}, 32'h0);
    chk("R7 released after NACK", {31'h0, sda_oe}, 32'h0);
    bus_stop();
  endtask

  task automatic t_block_long();
    logic a0, a1, a2, a;
    int nacks;
    nacks = 0;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h00, a1);
    wr_byte(8'd10, a2);
    for (int i = 0; i < 10; i++) begin
      wr_byte(8'h40 + 8'(i), a);
      if (!a) nacks++;
    end
    bus_stop();
    chk("R8 long block header acks", {29'h0, a0, a1, a2}, 32'h7);
    chk("R8 long block every byte acked", nacks, 0);
    for (int i = 0; i < 7; i++) exp_reg[i] = 8'h40 + 8'(i);
    chk_regs("R9 bank after long block write");
  endtask

  task automatic t_ro_and_range();
    byte_write("R9 byte write ofs7", 5'd7, 8'h5A);
    chk_regs("R9 ofs7 unchanged");
    byte_write("R8 byte write ofs20", 5'd20, 8'hEE);
    chk_regs("R8 ofs20 discarded");
    byte_read("R8 byte read ofs20", 5'd20, 8'h00);
  endtask

  task automatic t_wrong_addr();
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'hA0, a0);
    wr_byte(8'h82, a1);
    wr_byte(8'h00, a2);
    bus_stop();
    chk("R2 foreign address not acked", {29'h0, a0, a1, a2}, 32'h0);
    chk_regs("R2 bank after foreign address");
  endtask

  task automatic t_chip_sel();
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'hA3, a1);
    wr_byte(8'h00, a2);
    bus_stop();
    chk("R4 address acked", {31'h0, a0}, 32'h1);
    chk("R4 bad chip select not acked", {30'h0, a1, a2}, 32'h0);
    chk_regs("R4 bank after bad chip select");
  endtask

  task automatic t_abort();
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h82, a1);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_stop();
    chk("R10 STOP abort setup acks", {30'h0, a0, a1}, 32'h3);
    chk("R10 SDA free after STOP abort", {31'h0, sda_oe}, 32'h0);
    chk_regs("R10 bank after STOP abort");
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h81, a1);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h81, a1);
    wr_byte(8'h99, a2);
    bus_stop();
    chk("R10 transfer after START abort acks", {29'h0, a0, a1, a2}, 32'h7);
    exp_reg[1] = 8'h99;
    chk_regs("R10 bank after START abort");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    exp_reg[0] = 8'h7C; exp_reg[1] = 8'h00; exp_reg[2] = 8'hEB; exp_reg[3] = 8'hBF;
    exp_reg[4] = 8'h01; exp_reg[5] = 8'h00; exp_reg[6] = 8'h13; exp_reg[7] = 8'h38;
    tick(5);
    rst = 1'b0;
    tick(3);
    t_reset();
    t_byte_ops();
    t_block_short();
    t_block_read();
    t_block_long();
    t_ro_and_range();
    t_wrong_addr();
    t_chip_sel();
    t_abort();
    tick(5);
    chk("R11 SDA moves during SCL high", hi_moves, 0);
    finish_run();
  end

endmodule